// File: doc/BRIEF.md
# Strobe Timing Converter

This block turns a set of edge and cycle timing requests for a parallel display bus into the two packed tick-count words that a strobe sequencer loads. Every request is given in picoseconds, and so is the period of the functional clock. The requests cover the chip-select, write-strobe and read-strobe assert and release times, the write and read cycle times, the read access time and the chip-select pulse width. Each request is turned into a whole number of ticks, rounding up.

Some requests break the ordering the sequencer relies on. The block does not reject them. It raises the offending value instead: a release time goes above its assert time, chip-select release moves past both strobe releases, access time goes past read assert, and each cycle time is at least its strobe release. It first tries a tick of one clock period. If any field would overflow its width, it tries again with a tick of two periods. It reports failure only when both attempts overflow. The caller pulses `start`, waits for `done`, and then reads `ok`, the granularity bit and the two words.

Top module: `strobe_timing_conv`

## Requirements
- R1: Each field's tick count is the request divided by (period × divider), rounded up. A request of zero gives zero ticks.
- R2: For the write strobe, the read strobe and chip-select alike, a release tick count that is not above its assert count is replaced by assert + 1.
- R3: After R2, chip-select release is raised to the larger of the write and read release counts whenever it is below that value.
- R4: Access time is raised to read assert + 1 when it is not above read assert.
- R5: Write cycle time is raised to write release, and read cycle time to read release, whenever it is below that value.
- R6: After adjustment, the three assert counts must be at most 15 and all other fields at most 63. Any overflow rejects that divider. A value of exactly 15 or 63 fits.
- R7: Divider 1 is tried before divider 2. The `gran` output equals divider − 1 of the accepted attempt.
- R8: `edge_word` packs CS-assert in bits 3:0, CS-release in bits 9:4, WE-assert in bits 13:10, WE-release in bits 19:14, RE-assert in bits 23:20 and RE-release in bits 29:24. `cycle_word` packs write cycle in bits 5:0, read cycle in bits 11:6, CS pulse in bits 17:12 and access in bits 27:22. All other bits are zero.
- R9: A `start` pulse while `busy` is low captures all inputs and yields exactly one single-cycle `done` with a valid `ok`. A `start` while `busy` is high is ignored.
- R10: When both dividers fail, `ok` is 0 and `edge_word`, `cycle_word` and `gran` keep their previous values.
- R11: A clock period of zero makes every attempt fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (one-cycle pulse) |
| period_ps | input | PER_W | Functional clock period in ps |
| cs_on_ps | input | TIME_W | Chip-select assert time |
| cs_off_ps | input | TIME_W | Chip-select release time |
| we_on_ps | input | TIME_W | Write strobe assert time |
| we_off_ps | input | TIME_W | Write strobe release time |
| re_on_ps | input | TIME_W | Read strobe assert time |
| re_off_ps | input | TIME_W | Read strobe release time |
| we_cyc_ps | input | TIME_W | Write cycle time |
| re_cyc_ps | input | TIME_W | Read cycle time |
| access_ps | input | TIME_W | Read access time |
| cs_pulse_ps | input | TIME_W | Chip-select pulse width |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result of the last conversion |
| gran | output | 1 | Tick granularity (divider − 1) |
| edge_word | output | 32 | Packed assert/release counts |
| cycle_word | output | 32 | Packed cycle/pulse/access counts |

## Verification
Several request sets are applied, and each one exercises a single rule. One set has values that all fit and are already well ordered; it checks the rounding and the bit packing. Other sets equate or invert each release/assert pair, shrink chip-select release, access time and the cycle times, and so separate the bump rules from one another. Assert times of exactly 15 ticks and of 16 ticks show the field limit and the fallback to the coarser tick. A set that overflows at both dividers, and a zero clock period, confirm that a failure leaves the previous words in place. A second `start` issued mid-conversion must neither produce an extra `done` nor change the result.

// File: rtl/stc_pkg.sv
package stc_pkg;

  localparam int NFIELD = 10;
  localparam int ON_MAX  = 15;
  localparam int FLD_MAX = 63;

  localparam int IX_CS_ON  = 0;
  localparam int IX_CS_OFF = 1;
  localparam int IX_WE_ON  = 2;
  localparam int IX_WE_OFF = 3;
  localparam int IX_RE_ON  = 4;
  localparam int IX_RE_OFF = 5;
  localparam int IX_WE_CYC = 6;
  localparam int IX_RE_CYC = 7;
  localparam int IX_ACCESS = 8;
  localparam int IX_CS_PUL = 9;

  typedef logic [NFIELD-1:0][31:0] tick_vec_t;

  typedef struct packed {
    logic        ok;
    logic [31:0] edge_w;
    logic [31:0] cyc_w;
  } fit_t;

  // Repair ordering, check field limits, pack words
  function automatic fit_t fit_fields(input tick_vec_t t);
    logic [31:0] cson, csoff, weon, weoff, reon, reoff, wecyc, recyc, act, csp;
    fit_t r;
    cson  = t[IX_CS_ON];   csoff = t[IX_CS_OFF];
    weon  = t[IX_WE_ON];   weoff = t[IX_WE_OFF];
    reon  = t[IX_RE_ON];   reoff = t[IX_RE_OFF];
    wecyc = t[IX_WE_CYC];  recyc = t[IX_RE_CYC];
    act   = t[IX_ACCESS];  csp   = t[IX_CS_PUL];
    if (weoff <= weon) weoff = weon + 32'd1;
    if (reoff <= reon) reoff = reon + 32'd1;
    if (csoff <= cson) csoff = cson + 32'd1;
    if (csoff < weoff) csoff = weoff;
    if (csoff < reoff) csoff = reoff;
    if (act <= reon)   act   = reon + 32'd1;
    if (wecyc < weoff) wecyc = weoff;
    if (recyc < reoff) recyc = reoff;
    r.ok = (cson <= ON_MAX) && (weon <= ON_MAX) && (reon <= ON_MAX) &&
           (csoff <= FLD_MAX) && (weoff <= FLD_MAX) && (reoff <= FLD_MAX) &&
           (wecyc <= FLD_MAX) && (recyc <= FLD_MAX) && (act <= FLD_MAX) &&
           (csp <= FLD_MAX);
    r.edge_w = {2'b00, reoff[5:0], reon[3:0], weoff[5:0], weon[3:0],
                csoff[5:0], cson[3:0]};
    r.cyc_w  = {4'b0000, act[5:0], 4'b0000, csp[5:0], recyc[5:0], wecyc[5:0]};
    return r;
  endfunction

endpackage

// File: rtl/stc_divider.sv
module stc_divider #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot,
  output logic [DEN_W-1:0] rem
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [NUM_W-1:0] qr;
  logic [DEN_W-1:0] rr, dr;
  logic [DEN_W:0]   trial, diff;
  logic             fits;

  assign trial = {rr, qr[NUM_W-1]};
  assign fits  = trial >= {1'b0, dr};
  assign diff  = trial - {1'b0, dr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; done <= 1'b0; cnt <= '0;
      qr <= '0; rr <= '0; dr <= '0;
    end else begin
      done <= 1'b0;
      if (start && !run) begin
        run <= 1'b1;
        cnt <= CNT_W'(NUM_W);
        qr  <= num;
        rr  <= '0;
        dr  <= den;
      end else if (run) begin
        rr  <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        qr  <= {qr[NUM_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = qr;
  assign rem  = rr;

  // R1: a finished division leaves a remainder below the divisor
  assert_rem_below_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dr != '0) |-> (rr < dr));

endmodule

// File: rtl/stc_field_fit.sv
module stc_field_fit
  import stc_pkg::*;
(
  input  tick_vec_t   ticks,
  output logic        fit_ok,
  output logic [31:0] edge_w,
  output logic [31:0] cyc_w
);
  fit_t res;
  assign res    = fit_fields(ticks);
  assign fit_ok = res.ok;
  assign edge_w = res.edge_w;
  assign cyc_w  = res.cyc_w;
endmodule

// File: rtl/strobe_timing_conv.sv
module strobe_timing_conv
  import stc_pkg::*;
#(
  parameter int TIME_W = 20,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PER_W-1:0]  period_ps,
  input  logic [TIME_W-1:0] cs_on_ps,
  input  logic [TIME_W-1:0] cs_off_ps,
  input  logic [TIME_W-1:0] we_on_ps,
  input  logic [TIME_W-1:0] we_off_ps,
  input  logic [TIME_W-1:0] re_on_ps,
  input  logic [TIME_W-1:0] re_off_ps,
  input  logic [TIME_W-1:0] we_cyc_ps,
  input  logic [TIME_W-1:0] re_cyc_ps,
  input  logic [TIME_W-1:0] access_ps,
  input  logic [TIME_W-1:0] cs_pulse_ps,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              gran,
  output logic [31:0]       edge_word,
  output logic [31:0]       cycle_word
);
  localparam int DEN_W = PER_W + 1;
  localparam int IDX_W = $clog2(NFIELD);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_FIT} state_t;
  state_t state;

  logic [NFIELD-1:0][TIME_W-1:0] req_q;
  logic [PER_W-1:0]  per_q;
  tick_vec_t         ticks;
  logic [IDX_W-1:0]  idx;
  logic              div2;

  logic              div_start, div_done;
  logic [DEN_W-1:0]  tick_ps;
  logic [TIME_W-1:0] quot;
  logic [DEN_W-1:0]  rem;
  logic [31:0]       ceil_val;
  logic              fit_ok;
  logic [31:0]       fit_edge, fit_cyc;

  assign div_start = (state == S_LOAD);
  assign tick_ps   = div2 ? {per_q, 1'b0} : {1'b0, per_q};
  assign ceil_val  = 32'(quot) + {31'b0, |rem};

  stc_divider #(.NUM_W(TIME_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(req_q[idx]),
    .den(tick_ps), .done(div_done), .quot(quot), .rem(rem)
  );

  stc_field_fit u_fit (
    .ticks(ticks), .fit_ok(fit_ok), .edge_w(fit_edge), .cyc_w(fit_cyc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; req_q <= '0; per_q <= '0; ticks <= '0;
      idx <= '0; div2 <= 1'b0; done <= 1'b0; ok <= 1'b0; gran <= 1'b0;
      edge_word <= '0; cycle_word <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          req_q <= {cs_pulse_ps, access_ps, re_cyc_ps, we_cyc_ps, re_off_ps,
                    re_on_ps, we_off_ps, we_on_ps, cs_off_ps, cs_on_ps};
          per_q <= period_ps;
          idx   <= '0;
          div2  <= 1'b0;
          state <= S_LOAD;
        end
        S_LOAD: state <= S_WAIT;
        S_WAIT: if (div_done) begin
          ticks[idx] <= ceil_val;
          if (idx == IDX_W'(NFIELD - 1)) state <= S_FIT;
          else begin
            idx   <= idx + 1'b1;
            state <= S_LOAD;
          end
        end
        S_FIT: begin
          if (fit_ok) begin
            edge_word  <= fit_edge;
            cycle_word <= fit_cyc;
            gran  <= div2;
            ok    <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (!div2) begin
            div2  <= 1'b1;
            idx   <= '0;
            state <= S_LOAD;
          end else begin
            ok    <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  // R2..R5: an accepted result always satisfies the ordering rules
  assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |->
      (edge_word[19:14] > 6'(edge_word[13:10])) &&
      (edge_word[29:24] > 6'(edge_word[23:20])) &&
      (edge_word[9:4]   > 6'(edge_word[3:0]))   &&
      (edge_word[9:4]  >= edge_word[19:14])     &&
      (edge_word[9:4]  >= edge_word[29:24])     &&
      (cycle_word[27:22] > 6'(edge_word[23:20])) &&
      (cycle_word[5:0]  >= edge_word[19:14])    &&
      (cycle_word[11:6] >= edge_word[29:24]));

  // R10: a failed conversion leaves the words untouched
  assert_keep_on_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> ($stable(edge_word) && $stable(cycle_word) && $stable(gran)));

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a start during a conversion does not restart or end it early
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != S_FIT) |=> busy);

  // R8: unused bit positions stay zero
  assert_spare_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (edge_word[31:30] == 2'b00) && (cycle_word[31:28] == 4'h0) &&
             (cycle_word[21:18] == 4'h0));

endmodule

// File: tb/strobe_timing_conv_bench.sv
module strobe_timing_conv_bench;
  localparam int TIME_W = 20;
  localparam int PER_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PER_W-1:0] period_ps = '0;
  logic [TIME_W-1:0] tv [10];
  logic busy, done, ok, gran;
  logic [31:0] edge_word, cycle_word;

  always #2.5 clk = ~clk;  // 200 MHz

  strobe_timing_conv #(.TIME_W(TIME_W), .PER_W(PER_W)) u_strobe_timing_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
    .cs_on_ps(tv[0]), .cs_off_ps(tv[1]), .we_on_ps(tv[2]), .we_off_ps(tv[3]),
    .re_on_ps(tv[4]), .re_off_ps(tv[5]), .we_cyc_ps(tv[6]), .re_cyc_ps(tv[7]),
    .access_ps(tv[8]), .cs_pulse_ps(tv[9]),
    .busy(busy), .done(done), .ok(ok), .gran(gran),
    .edge_word(edge_word), .cycle_word(cycle_word));

  typedef struct {
    string       tag;
    bit          ok;
    bit          gran;
    logic [31:0] ew;
    logic [31:0] cw;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0, dones = 0, pushes = 0;
  bit          last_gran = 0;
  logic [31:0] last_ew = '0, last_cw = '0;

  task automatic chk(input string tag, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic int up_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // Independent reference model, written from the requirements
  function automatic exp_t model(input string tag, input int per);
    exp_t e;
    int v[10];
    e.tag = tag; e.ok = 0; e.gran = last_gran; e.ew = last_ew; e.cw = last_cw;
    for (int d = 1; d <= 2; d++) begin
      int tk;
      bit good;
      tk = per * d;
      if (tk == 0) continue;                        // R11
      foreach (v[i]) v[i] = up_div(int'(tv[i]), tk); // R1
      v[3] = (v[3] > v[2]) ? v[3] : v[2] + 1;       // R2
      v[5] = (v[5] > v[4]) ? v[5] : v[4] + 1;
      v[1] = (v[1] > v[0]) ? v[1] : v[0] + 1;
      v[1] = (v[1] >= v[3] && v[1] >= v[5]) ? v[1] : ((v[3] > v[5]) ? v[3] : v[5]); // R3
      v[8] = (v[8] > v[4]) ? v[8] : v[4] + 1;       // R4
      v[6] = (v[6] >= v[3]) ? v[6] : v[3];          // R5
      v[7] = (v[7] >= v[5]) ? v[7] : v[5];
      good = 1;                                     // R6
      foreach (v[i]) begin
        if ((i == 0 || i == 2 || i == 4) && v[i] > 15) good = 0;
        if (v[i] > 63) good = 0;
      end
      if (good) begin                               // R7, R8
        e.ok = 1; e.gran = (d == 2);
        e.ew = (v[5] << 24) | (v[4] << 20) | (v[3] << 14) | (v[2] << 10) | (v[1] << 4) | v[0];
        e.cw = (v[8] << 22) | (v[9] << 12) | (v[7] << 6) | v[6];
        return e;
      end
    end
    return e;
  endfunction

  // Monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      dones++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected done: actual 1 expected 0");
      end else begin
        e = exp_q.pop_front();
        chk(e.tag, "ok (R6)", ok, e.ok);
        chk(e.tag, "gran (R7)", gran, e.gran);
        chk(e.tag, "edge_word (R8)", edge_word, e.ew);
        chk(e.tag, "cycle_word (R8)", cycle_word, e.cw);
      end
    end
  end

  task automatic set_req(input int a0, a1, a2, a3, a4, a5, a6, a7, a8, a9);
    tv[0] = a0; tv[1] = a1; tv[2] = a2; tv[3] = a3; tv[4] = a4;
    tv[5] = a5; tv[6] = a6; tv[7] = a7; tv[8] = a8; tv[9] = a9;
  endtask

  // Driver: push expectation, pulse start, wait for completion
  task automatic convert(input string tag, input int per);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    period_ps = PER_W'(per);
    e = model(tag, per);
    exp_q.push_back(e); pushes++;
    last_gran = e.gran; last_ew = e.ew; last_cw = e.cw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    foreach (tv[i]) tv[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset", "busy", busy, 0);
    chk("reset", "done", done, 0);
    chk("reset", "edge_word", edge_word, 0);
    chk("reset", "cycle_word", cycle_word, 0);

    // R1 rounding with already well ordered values
    set_req(4000, 31000, 5000, 20001, 9999, 30000, 40000, 41000, 26000, 12345);
    convert("R1", 5000);
    // R2 release equal to / below assert
    set_req(10000, 10000, 15000, 15000, 20000, 5000, 0, 0, 60000, 0);
    convert("R2", 5000);
    // R3 chip-select release below strobe releases
    set_req(0, 5000, 5000, 90000, 5000, 70000, 100000, 100000, 40000, 0);
    convert("R3", 5000);
    // R4 access not beyond read assert
    set_req(0, 60000, 0, 10000, 45000, 50000, 60000, 60000, 0, 5000);
    convert("R4", 5000);
    // R5 cycle times shorter than releases
    set_req(0, 200000, 0, 150000, 0, 180000, 1000, 2000, 10000, 0);
    convert("R5", 5000);
    // R6 boundary: assert of exactly 15 ticks and release of exactly 63
    set_req(75000, 315000, 0, 5000, 0, 5000, 5000, 5000, 5000, 315000);
    convert("R6", 5000);
    // R7 fallback to divider 2 when an assert needs 16 ticks
    set_req(0, 5000, 75001, 80000, 0, 5000, 5000, 5000, 5000, 0);
    convert("R7", 5000);
    // R10 both dividers overflow
    set_req(0, 700000, 0, 5000, 0, 5000, 5000, 5000, 5000, 0);
    convert("R10", 5000);
    // R11 zero clock period
    set_req(0, 5000, 0, 5000, 0, 5000, 5000, 5000, 5000, 0);
    convert("R11", 0);
    // R1 different period, recovery after failure
    set_req(3000, 27000, 1000, 11000, 2000, 13000, 18000, 19000, 14000, 9000);
    convert("R1", 3000);

    // R9: start while busy is ignored
    begin
      exp_t e;
      @(negedge clk);
      set_req(1000, 9000, 2000, 7000, 3000, 8000, 12000, 12000, 6000, 4000);
      period_ps = PER_W'(1000);
      e = model("R9", 1000);
      exp_q.push_back(e); pushes++;
      last_gran = e.gran; last_ew = e.ew; last_cw = e.cw;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      set_req(0, 700000, 0, 0, 0, 0, 0, 0, 0, 0);
      period_ps = PER_W'(1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (600) @(negedge clk);
      chk("R9", "done count", dones, pushes);
      chk("R9", "busy after ignore", busy, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule